// File: doc/BRIEF.md
# Operand Effective Address Unit

This unit resolves where the source operand of an instruction lives. It receives a three-bit addressing-mode code, a register selector, the full contents of a sixteen-entry register file, the program counter value that points at the extension word, the extension word itself and a byte/word flag. From these it reports whether the operand is a register, an immediate value or a memory location, and gives the register value, the immediate value or the effective address to match.

It also reports two side effects. The first is a need-extension flag, which tells the fetch stage to consume the extension word and step its program counter by two. The second is a register write-back strobe with a target register and a new value, used when the post-increment mode bumps its pointer register by the operand size.

A request is sampled on a rising clock edge while `req_valid` is high. The result is presented for one cycle after that edge, and back-to-back requests give back-to-back results.

A small two-state machine sequences the results. `ST_IDLE` means no result is presented. `ST_RESULT` means a result is on the outputs. The machine moves `ST_IDLE -> ST_RESULT` when a request is sampled, stays in `ST_RESULT` while requests keep arriving, and moves `ST_RESULT -> ST_IDLE` on an edge with no request. An active-low asynchronous reset forces `ST_IDLE` and clears every output.

Top module: `opnd_ea_unit`

## Requirements
- R1: While reset is low, and at once when it falls, `res_valid`, `need_ext` and `wb_en` are 0, and `opnd_kind`, `opnd_value`, `eff_addr`, `wb_reg` and `wb_data` are 0. A request presented during reset produces no result.
- R2: A request sampled on a rising edge shows `res_valid`=1 with its result after that same edge. Consecutive requests give consecutive results. On an edge with no request, `res_valid` returns to 0 and every other output returns to 0.
- R3: Mode code 0 (register) and the spare code 7 give `opnd_kind`=0 (register) and `opnd_value` = the selected register. They give `eff_addr`=0, `need_ext`=0 and `wb_en`=0.
- R4: Mode code 1 (immediate) gives `opnd_kind`=1, `opnd_value` = extension word, `eff_addr`=0 and `need_ext`=1.
- R5: Mode code 2 (absolute) gives `opnd_kind`=2 (memory), `eff_addr` = extension word, `opnd_value`=0 and `need_ext`=1.
- R6: Mode code 3 (indexed) gives `opnd_kind`=2, `eff_addr` = selected register + extension word modulo 2^16, and `need_ext`=1.
- R7: Mode code 4 (PC-relative) gives `opnd_kind`=2, `eff_addr` = `pc_ext` + extension word modulo 2^16, and `need_ext`=1. Here `pc_ext` is the address of the extension word.
- R8: Mode code 5 (register indirect) gives `opnd_kind`=2, `eff_addr` = selected register, `need_ext`=0 and `wb_en`=0.
- R9: Mode code 6 (post-increment) gives `opnd_kind`=2 and `eff_addr` = selected register (the value before the increment), with `need_ext`=0. It also gives `wb_en`=1, `wb_reg` = selector, and `wb_data` = register + 1 when `byte_op`=1 or + 2 when `byte_op`=0, modulo 2^16.
- R10: `byte_op` has no effect on any output in any mode other than code 6.
- R11: All sixteen registers, selectors 0 through 15, serve as operand, base or pointer registers. Register k occupies bits [16k+15:16k] of `reg_file`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| mode_code | input | 3 | Addressing-mode code (0..7) |
| reg_sel | input | 4 | Register selector |
| byte_op | input | 1 | 1 = byte operation, 0 = word operation |
| reg_file | input | 256 | Register file contents, register k in bits [16k+15:16k] |
| pc_ext | input | 16 | Program counter pointing at the extension word |
| ext_word | input | 16 | Extension word following the opcode |
| res_valid | output | 1 | Result presented |
| opnd_kind | output | 2 | 0 register, 1 immediate, 2 memory |
| opnd_value | output | 16 | Register or immediate operand value |
| eff_addr | output | 16 | Memory effective address |
| need_ext | output | 1 | Fetch stage must consume the extension word |
| wb_en | output | 1 | Register write-back strobe |
| wb_reg | output | 4 | Write-back register number |
| wb_data | output | 16 | Write-back value |

## Verification
If the state register is stuck or wrong, `res_valid` goes missing on the edge after a request, or stays high for one edge after the last request. The bench catches this at the first result or the first gap. A wrong mode class shows at once in that request's result as a wrong `opnd_kind` or a misplaced `need_ext` or `wb_en`. A wrong base or step shows in the same cycle as a wrong `eff_addr` or `wb_data`, and the bench forces the sums to wrap past 0xFFFF so that a carry error is exposed as well.

// File: rtl/eau_pkg.sv
package eau_pkg;

    typedef enum logic [2:0] {
        AM_REG = 3'd0,
        AM_IMM = 3'd1,
        AM_ABS = 3'd2,
        AM_IDX = 3'd3,
        AM_SYM = 3'd4,
        AM_IND = 3'd5,
        AM_INC = 3'd6,
        AM_RSV = 3'd7
    } mode_t;

    typedef enum logic [1:0] {
        OK_REG = 2'd0,
        OK_IMM = 2'd1,
        OK_MEM = 2'd2
    } kind_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } state_t;

endpackage

// File: rtl/eau_regmux.sv
module eau_regmux #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 16,
    localparam int SEL_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS*DATA_W-1:0] flat_regs,
    input  logic [SEL_W-1:0]           sel,
    output logic [DATA_W-1:0]          data
);

    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_unpack
        assign regs[g] = flat_regs[g*DATA_W +: DATA_W];
    end

    assign data = regs[sel];

endmodule

// File: rtl/eau_addr_calc.sv
module eau_addr_calc
    import eau_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  mode_t             mode,
    input  logic [DATA_W-1:0] rn,
    input  logic [DATA_W-1:0] pc_ext,
    input  logic [DATA_W-1:0] ext_word,
    output kind_t             kind,
    output logic [DATA_W-1:0] value,
    output logic [DATA_W-1:0] eff,
    output logic              need_ext
);

    logic [DATA_W-1:0] base;
    logic [DATA_W-1:0] sum;

    // one shared adder: register base for indexed, PC base for PC-relative
    always_comb begin
        base = (mode == AM_SYM) ? pc_ext : rn;
        sum  = base + ext_word;
    end

    always_comb begin
        kind     = OK_MEM;
        value    = '0;
        eff      = '0;
        need_ext = 1'b0;
        unique case (mode)
            AM_REG, AM_RSV: begin
                kind  = OK_REG;
                value = rn;
            end
            AM_IMM: begin
                kind     = OK_IMM;
                value    = ext_word;
                need_ext = 1'b1;
            end
            AM_ABS: begin
                eff      = ext_word;
                need_ext = 1'b1;
            end
            AM_IDX, AM_SYM: begin
                eff      = sum;
                need_ext = 1'b1;
            end
            AM_IND, AM_INC: begin
                eff = rn;
            end
        endcase
    end

endmodule

// File: rtl/eau_incr.sv
module eau_incr #(
    parameter int DATA_W = 16
) (
    input  logic              active,
    input  logic              byte_op,
    input  logic [DATA_W-1:0] rn,
    output logic              wb_en,
    output logic [DATA_W-1:0] wb_data
);

    localparam logic [DATA_W-1:0] STEP_BYTE = DATA_W'(1);
    localparam logic [DATA_W-1:0] STEP_WORD = DATA_W'(2);

    always_comb begin
        wb_en   = active;
        wb_data = '0;
        if (active) begin
            wb_data = rn + (byte_op ? STEP_BYTE : STEP_WORD);
        end
    end

endmodule

// File: rtl/opnd_ea_unit.sv
module opnd_ea_unit
    import eau_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 16,
    localparam int SEL_W   = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [2:0]                 mode_code,
    input  logic [SEL_W-1:0]           reg_sel,
    input  logic                       byte_op,
    input  logic [NUM_REGS*DATA_W-1:0] reg_file,
    input  logic [DATA_W-1:0]          pc_ext,
    input  logic [DATA_W-1:0]          ext_word,
    output logic                       res_valid,
    output logic [1:0]                 opnd_kind,
    output logic [DATA_W-1:0]          opnd_value,
    output logic [DATA_W-1:0]          eff_addr,
    output logic                       need_ext,
    output logic                       wb_en,
    output logic [SEL_W-1:0]           wb_reg,
    output logic [DATA_W-1:0]          wb_data
);

    mode_t             mode;
    logic [DATA_W-1:0] rn;
    kind_t             kind_d;
    logic [DATA_W-1:0] value_d;
    logic [DATA_W-1:0] eff_d;
    logic              need_d;
    logic              wb_en_d;
    logic [DATA_W-1:0] wb_data_d;

    state_t state_q;
    state_t state_d;

    kind_t             kind_q;
    logic [DATA_W-1:0] value_q;
    logic [DATA_W-1:0] eff_q;
    logic              need_q;
    logic              wb_en_q;
    logic [SEL_W-1:0]  wb_reg_q;
    logic [DATA_W-1:0] wb_data_q;

    assign mode = mode_t'(mode_code);

    eau_regmux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regmux (
        .flat_regs (reg_file),
        .sel       (reg_sel),
        .data      (rn)
    );

    eau_addr_calc #(.DATA_W(DATA_W)) u_addr_calc (
        .mode     (mode),
        .rn       (rn),
        .pc_ext   (pc_ext),
        .ext_word (ext_word),
        .kind     (kind_d),
        .value    (value_d),
        .eff      (eff_d),
        .need_ext (need_d)
    );

    eau_incr #(.DATA_W(DATA_W)) u_incr (
        .active  (mode == AM_INC),
        .byte_op (byte_op),
        .rn      (rn),
        .wb_en   (wb_en_d),
        .wb_data (wb_data_d)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid)  state_d = ST_RESULT;
            ST_RESULT: if (!req_valid) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers: load a result on a request, clear otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q    <= OK_REG;
            value_q   <= '0;
            eff_q     <= '0;
            need_q    <= 1'b0;
            wb_en_q   <= 1'b0;
            wb_reg_q  <= '0;
            wb_data_q <= '0;
        end else if (req_valid) begin
            kind_q    <= kind_d;
            value_q   <= value_d;
            eff_q     <= eff_d;
            need_q    <= need_d;
            wb_en_q   <= wb_en_d;
            wb_reg_q  <= wb_en_d ? reg_sel : '0;
            wb_data_q <= wb_data_d;
        end else begin
            kind_q    <= OK_REG;
            value_q   <= '0;
            eff_q     <= '0;
            need_q    <= 1'b0;
            wb_en_q   <= 1'b0;
            wb_reg_q  <= '0;
            wb_data_q <= '0;
        end
    end

    assign res_valid  = (state_q == ST_RESULT);
    assign opnd_kind  = kind_q;
    assign opnd_value = value_q;
    assign eff_addr   = eff_q;
    assign need_ext   = need_q;
    assign wb_en      = wb_en_q;
    assign wb_reg     = wb_reg_q;
    assign wb_data    = wb_data_q;

    // R2
    result_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!need_ext && !wb_en));

    // R9
    wb_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (res_valid && opnd_kind == 2'd2));

    // R9
    wb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> ((wb_data == eff_addr + DATA_W'(1)) || (wb_data == eff_addr + DATA_W'(2))));

    // R3
    reg_kind_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && opnd_kind == 2'd0) |-> (!need_ext && !wb_en && eff_addr == '0));

    // R6
    idx_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == AM_IDX) |=> (eff_addr == $past(rn + ext_word) && need_ext));

endmodule

// File: tb/test_opnd_ea_unit.sv
module test_opnd_ea_unit;

    localparam int NV = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [2:0]   mode_code = '0;
    logic [3:0]   reg_sel = '0;
    logic         byte_op = 1'b0;
    logic [255:0] reg_file;
    logic [15:0]  pc_ext = '0;
    logic [15:0]  ext_word = '0;
    logic         res_valid;
    logic [1:0]   opnd_kind;
    logic [15:0]  opnd_value;
    logic [15:0]  eff_addr;
    logic         need_ext;
    logic         wb_en;
    logic [3:0]   wb_reg;
    logic [15:0]  wb_data;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    opnd_ea_unit i_opnd_ea_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode_code(mode_code),
        .reg_sel(reg_sel), .byte_op(byte_op), .reg_file(reg_file), .pc_ext(pc_ext),
        .ext_word(ext_word), .res_valid(res_valid), .opnd_kind(opnd_kind),
        .opnd_value(opnd_value), .eff_addr(eff_addr), .need_ext(need_ext),
        .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data)
    );

    // stimulus {mode, sel, byte, pc, ext} then expected {kind, value, eff, need, wb, wbdata}
    localparam logic [91:0] VEC [NV] = '{
        {3'd0, 4'd5,  1'b0, 16'h1000, 16'hABCD, 2'd0, 16'h5555, 16'h0000, 1'b0, 1'b0, 16'h0000},
        {3'd7, 4'd3,  1'b0, 16'h1000, 16'h1234, 2'd0, 16'h3333, 16'h0000, 1'b0, 1'b0, 16'h0000},
        {3'd1, 4'd2,  1'b0, 16'h2000, 16'hBEEF, 2'd1, 16'hBEEF, 16'h0000, 1'b1, 1'b0, 16'h0000},
        {3'd2, 4'd7,  1'b0, 16'h2000, 16'h0200, 2'd2, 16'h0000, 16'h0200, 1'b1, 1'b0, 16'h0000},
        {3'd3, 4'd4,  1'b0, 16'h3000, 16'h0010, 2'd2, 16'h0000, 16'h4454, 1'b1, 1'b0, 16'h0000},
        {3'd3, 4'd15, 1'b1, 16'h3000, 16'h0002, 2'd2, 16'h0000, 16'h0001, 1'b1, 1'b0, 16'h0000},
        {3'd4, 4'd9,  1'b0, 16'hF000, 16'h2000, 2'd2, 16'h0000, 16'h1000, 1'b1, 1'b0, 16'h0000},
        {3'd4, 4'd0,  1'b0, 16'h0100, 16'h0020, 2'd2, 16'h0000, 16'h0120, 1'b1, 1'b0, 16'h0000},
        {3'd5, 4'd6,  1'b0, 16'h4000, 16'h9999, 2'd2, 16'h0000, 16'h6666, 1'b0, 1'b0, 16'h0000},
        {3'd5, 4'd6,  1'b1, 16'h4000, 16'h9999, 2'd2, 16'h0000, 16'h6666, 1'b0, 1'b0, 16'h0000},
        {3'd6, 4'd8,  1'b0, 16'h4000, 16'h0000, 2'd2, 16'h0000, 16'h8888, 1'b0, 1'b1, 16'h888A},
        {3'd6, 4'd8,  1'b1, 16'h4000, 16'h0000, 2'd2, 16'h0000, 16'h8888, 1'b0, 1'b1, 16'h8889},
        {3'd6, 4'd15, 1'b0, 16'h4000, 16'h0000, 2'd2, 16'h0000, 16'hFFFF, 1'b0, 1'b1, 16'h0001},
        {3'd6, 4'd15, 1'b1, 16'h4000, 16'h0000, 2'd2, 16'h0000, 16'hFFFF, 1'b0, 1'b1, 16'h0000},
        {3'd0, 4'd0,  1'b1, 16'h5000, 16'h7777, 2'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000},
        {3'd0, 4'd15, 1'b0, 16'h5000, 16'h7777, 2'd0, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 16'h0000}
    };

    localparam string TAG [NV] = '{
        "R3", "R3", "R4", "R5", "R6", "R6/R10", "R7", "R7",
        "R8", "R8/R10", "R9", "R9", "R9", "R9", "R11/R10", "R11"
    };

    task automatic chk(input string req, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input int i);
        req_valid = 1'b1;
        mode_code = VEC[i][91:89];
        reg_sel   = VEC[i][88:85];
        byte_op   = VEC[i][84];
        pc_ext    = VEC[i][83:68];
        ext_word  = VEC[i][67:52];
    endtask

    task automatic check_vec(input int i);
        logic [3:0] exp_wbreg;
        exp_wbreg = VEC[i][17] ? VEC[i][88:85] : 4'd0;
        chk(TAG[i], "res_valid R2", {15'd0, res_valid}, 16'd1);
        chk(TAG[i], "kind",   {14'd0, opnd_kind}, {14'd0, VEC[i][51:50]});
        chk(TAG[i], "value",  opnd_value, VEC[i][49:34]);
        chk(TAG[i], "eff",    eff_addr, VEC[i][33:18]);
        chk(TAG[i], "need",   {15'd0, need_ext}, {15'd0, VEC[i][17]});
        chk(TAG[i], "wb_en",  {15'd0, wb_en}, {15'd0, VEC[i][16]});
        chk(TAG[i], "wb_reg", {12'd0, wb_reg}, {12'd0, (VEC[i][16] ? VEC[i][88:85] : 4'd0)});
        chk(TAG[i], "wb_data", wb_data, VEC[i][15:0]);
        if (exp_wbreg == 4'hF) begin end
    endtask

    task automatic check_quiet(input string req);
        chk(req, "res_valid", {15'd0, res_valid}, 16'd0);
        chk(req, "need",      {15'd0, need_ext}, 16'd0);
        chk(req, "wb_en",     {15'd0, wb_en}, 16'd0);
        chk(req, "eff",       eff_addr, 16'd0);
        chk(req, "wb_data",   wb_data, 16'd0);
    endtask

    initial begin
        for (int k = 0; k < 16; k++) reg_file[k*16 +: 16] = {4{k[3:0]}};
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state, with a request held during reset
        req_valid = 1'b1;
        mode_code = 3'd6;
        reg_sel   = 4'd2;
        repeat (3) @(negedge clk);
        check_quiet("R1");
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R1");

        // table walk: back-to-back requests
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            if (i > 0) check_vec(i - 1);
            drive(i);
        end
        @(negedge clk);
        check_vec(NV - 1);
        req_valid = 1'b0;

        // R2: result drops on a cycle with no request
        @(negedge clk);
        check_quiet("R2");

        // R10: byte flag does not alter an immediate result
        drive(2);
        byte_op = 1'b1;
        @(negedge clk);
        chk("R10", "imm value", opnd_value, 16'hBEEF);
        chk("R10", "imm need", {15'd0, need_ext}, 16'd1);
        req_valid = 1'b0;
        @(negedge clk);

        // R2: single isolated request, then gap
        drive(10);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2", "isolated wb_en", {15'd0, wb_en}, 16'd1);
        @(negedge clk);
        check_quiet("R2");

        // R1: reset falling mid-result clears outputs at once
        drive(12);
        @(negedge clk);
        chk("R9", "pre-reset wb_data", wb_data, 16'h0001);
        rst_n = 1'b0;
        #1;
        check_quiet("R1");
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R1");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule